// File: doc/BRIEF.md
# Inter-Core Mailbox Bank

The block holds a bank of 32-bit mailboxes that cores use to signal one another and to hand over boot information. There are four cores with four mailboxes each, so sixteen in all. A mailbox is numbered n = 4*core + slot. Software changes a mailbox through two address windows. In the set window, every one bit of the written word is ORed into the mailbox. In the clear window, every one bit of the written word clears that bit of the mailbox. Reading an address in the clear window returns what the mailbox holds.

Each mailbox drives a level output that is high for as long as any of its bits is one. These sixteen levels go to a per-core interrupt router outside the block, which enables and routes them. A core that receives a message reads its mailbox through the clear window. It then writes back the bits it has handled to the same address, which drops the level once the mailbox is empty.

Top module: `mbx_bank`

## Requirements
- R1: Mailbox n (n = 4*core + slot) is reached through set address 0x080 + 16*core + 4*slot and clear address 0x0C0 + 16*core + 4*slot. Address bits [1:0] must be zero for a match.
- R2: A write to a set address ORs the write data into that mailbox, and bits already set stay set.
- R3: Output mbox_irq[n] is high exactly while mailbox n holds a nonzero value. It follows a write from the clock edge that takes the write, so it is visible one cycle after the write is presented.
- R4: A write to a clear address clears every mailbox bit where the write data is one and keeps the other bits.
- R5: A read with rd_en high at a clear address returns the mailbox contents on rd_data one cycle later. A write to the same mailbox in that same cycle is not yet visible in the read.
- R6: A read at a set-window address returns zero.
- R7: Writes to addresses outside both windows, or to unaligned addresses, change no mailbox. Reads there return zero.
- R8: A write changes only the mailbox it addresses.
- R9: While rst is high, all mailboxes clear to zero, every mbox_irq bit is low and rd_data is zero.
- R10: rd_data is zero in any cycle that follows a cycle with rd_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data, used as a bit mask |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| mbox_irq | output | 16 | Per-mailbox nonzero level, index 4*core + slot |

## Verification
A mailbox register holding a wrong value can show up at the ports in two ways. It appears on its mbox_irq bit one cycle after the write that caused it, if the error changes whether the mailbox is zero. Otherwise it only appears one cycle after a read of the clear address. For this reason the bench checks the whole level vector after every write and reads back all sixteen mailboxes after each sweep of writes. A decode error that hits the wrong mailbox shows on the level of a mailbox that should not have changed, and in its readback. A read port that picks up the new value too early shows in the read-during-write case.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  // Which address window a bus address falls in.
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } mbx_win_e;

  localparam int BYTES_PER_BOX = 4;
endpackage

// File: rtl/mbx_addr_decode.sv
`timescale 1ns/1ps
module mbx_addr_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_BOX  = 16,
  parameter int SET_BASE = 128,
  parameter int CLR_BASE = 192
) (
  input  logic [ADDR_W-1:0]          addr,
  output mbx_win_e                   win,
  output logic [$clog2(NUM_BOX)-1:0] idx
);
  localparam int IDX_W = $clog2(NUM_BOX);

  logic [ADDR_W-1:0] set_off;
  logic [ADDR_W-1:0] clr_off;
  logic              set_in;
  logic              clr_in;

  // Offsets wrap below the base, so a single high-bits-zero test bounds both ends.
  always_comb begin
    set_off = addr - ADDR_W'(SET_BASE);
    clr_off = addr - ADDR_W'(CLR_BASE);
    set_in  = (set_off[ADDR_W-1:IDX_W+2] == '0) && (set_off[1:0] == 2'b00);
    clr_in  = (clr_off[ADDR_W-1:IDX_W+2] == '0) && (clr_off[1:0] == 2'b00);
    win     = WIN_NONE;
    idx     = '0;
    if (set_in) begin
      win = WIN_SET;
      idx = set_off[IDX_W+1:2];
    end else if (clr_in) begin
      win = WIN_CLR;
      idx = clr_off[IDX_W+1:2];
    end
  end

  // R1: the two windows never claim the same address
  always_comb begin
    assert_no_window_overlap_R1: assert (!(set_in && clr_in));
  end
endmodule

// File: rtl/mbx_cell.sv
`timescale 1ns/1ps
module mbx_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] val,
  output logic              irq
);
  logic [DATA_W-1:0] val_q;
  logic [DATA_W-1:0] nxt;
  logic              irq_q;

  // Clear is applied after set when both are present.
  always_comb begin
    nxt = (val_q | (set_en ? wdata : '0)) & ~(clr_en ? wdata : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      irq_q <= 1'b0;
    end else begin
      val_q <= nxt;
      irq_q <= |nxt;
    end
  end

  assign val = val_q;
  assign irq = irq_q;

  assert_set_bits_stick_R2: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr_en) |=> ((val & $past(wdata)) == $past(wdata)));

  assert_set_raises_level_R3: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr_en && (wdata != '0)) |=> irq);

  assert_full_clear_drops_level_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_en && (wdata == '1)) |=> (!irq && (val == '0)));

  assert_untouched_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> $stable(val));
endmodule

// File: rtl/mbx_read_port.sv
`timescale 1ns/1ps
module mbx_read_port
  import mbx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_BOX = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_en,
  input  mbx_win_e                          win,
  input  logic [$clog2(NUM_BOX)-1:0]        idx,
  input  logic [NUM_BOX-1:0][DATA_W-1:0]    boxes,
  output logic [DATA_W-1:0]                 rd_data
);
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en && (win == WIN_CLR)) begin
      rd_q <= boxes[idx];
    end else begin
      rd_q <= '0;
    end
  end

  assign rd_data = rd_q;

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
endmodule

// File: rtl/mbx_bank.sv
`timescale 1ns/1ps
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int BOX_PER_CORE  = 4,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 12,
  parameter int SET_BASE      = 128,
  parameter int CLR_BASE      = 192
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic                                 rd_en,
  input  logic [ADDR_W-1:0]                    rd_addr,
  output logic [DATA_W-1:0]                    rd_data,
  output logic [NUM_CORES*BOX_PER_CORE-1:0]    mbox_irq
);
  localparam int NUM_BOX = NUM_CORES * BOX_PER_CORE;
  localparam int IDX_W   = $clog2(NUM_BOX);

  mbx_win_e                     wwin;
  mbx_win_e                     rwin;
  logic [IDX_W-1:0]             widx;
  logic [IDX_W-1:0]             ridx;
  logic [NUM_BOX-1:0]           set_vec;
  logic [NUM_BOX-1:0]           clr_vec;
  logic [NUM_BOX-1:0][DATA_W-1:0] boxes;

  mbx_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_wdec (
    .addr(wr_addr), .win(wwin), .idx(widx)
  );

  mbx_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_rdec (
    .addr(rd_addr), .win(rwin), .idx(ridx)
  );

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
    assign set_vec[i] = wr_en && (wwin == WIN_SET) && (widx == IDX_W'(i));
    assign clr_vec[i] = wr_en && (wwin == WIN_CLR) && (widx == IDX_W'(i));

    mbx_cell #(.DATA_W(DATA_W)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_en(set_vec[i]),
      .clr_en(clr_vec[i]),
      .wdata (wr_data),
      .val   (boxes[i]),
      .irq   (mbox_irq[i])
    );
  end

  mbx_read_port #(.DATA_W(DATA_W), .NUM_BOX(NUM_BOX)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .win    (rwin),
    .idx    (ridx),
    .boxes  (boxes),
    .rd_data(rd_data)
  );

  assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_vec | clr_vec));

  assert_stray_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wwin == WIN_NONE)) |=> $stable(boxes));

  assert_read_returns_old_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rwin == WIN_CLR)) |=> (rd_data == $past(boxes[ridx])));

  assert_set_window_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rwin == WIN_SET)) |=> (rd_data == '0));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> ((mbox_irq == '0) && (rd_data == '0)));
endmodule

// File: tb/sim_mbx_bank.sv
`timescale 1ns/1ps
module sim_mbx_bank;
  localparam int NB = 16;
  localparam int DW = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic          rd_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic [NB-1:0] mbox_irq;

  always #4 clk = ~clk;

  mbx_bank u0 (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .mbox_irq(mbox_irq)
  );

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] exp_box [NB];

  function automatic logic [AW-1:0] set_addr(int i);
    return AW'(128 + 16 * (i / 4) + 4 * (i % 4));
  endfunction

  function automatic logic [AW-1:0] clr_addr(int i);
    return AW'(192 + 16 * (i / 4) + 4 * (i % 4));
  endfunction

  task automatic check32(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_irq(string tag);
    logic [NB-1:0] ev;
    for (int i = 0; i < NB; i++) ev[i] = |exp_box[i];
    check32(tag, DW'(mbox_irq), DW'(ev));
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic check_all_reads(string tag);
    logic [DW-1:0] v;
    for (int i = 0; i < NB; i++) begin
      do_read(clr_addr(i), v);
      check32(tag, v, exp_box[i]);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    for (int i = 0; i < NB; i++) exp_box[i] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check_irq("R9 reset irq");
    check32("R9 reset rd_data", rd_data, '0);
    rst = 1'b0;
    check_all_reads("R9 reset contents");

    // R1 R3 R8: set each mailbox in turn, level vector after each write
    for (int i = 0; i < NB; i++) begin
      do_write(set_addr(i), 32'h0001_0001 << i);
      exp_box[i] = exp_box[i] | (32'h0001_0001 << i);
      check_irq("R3 R8 level after set");
    end
    check_all_reads("R1 R5 readback after first sweep");

    // R6: set-window reads give zero
    for (int i = 0; i < NB; i++) begin
      do_read(set_addr(i), v);
      check32("R6 set window read", v, '0);
    end

    // R10: idle cycle after a read returns zero
    @(negedge clk);
    check32("R10 idle rd_data", rd_data, '0);

    // R2: OR a second pattern in
    for (int i = 0; i < NB; i++) begin
      do_write(set_addr(i), 32'h8000_0000 >> i);
      exp_box[i] = exp_box[i] | (32'h8000_0000 >> i);
    end
    check_all_reads("R2 OR accumulate");

    // R7: stray and unaligned writes change nothing
    do_write(12'h07C, '1);
    do_write(12'h100, '1);
    do_write(12'h0C2, '1);
    do_write(12'h081, '1);
    do_write(12'h0BE, '1);
    check_irq("R7 level after stray writes");
    check_all_reads("R7 contents after stray writes");
    do_read(12'h100, v);  check32("R7 stray read 0x100", v, '0);
    do_read(12'h0C1, v);  check32("R7 unaligned read 0x0C1", v, '0);
    do_read(12'h07C, v);  check32("R7 stray read 0x07C", v, '0);

    // R5: read in the same cycle as a write sees the old value
    @(negedge clk);
    wr_en = 1'b1; wr_addr = set_addr(5); wr_data = 32'h00F0_0000;
    rd_en = 1'b1; rd_addr = clr_addr(5);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check32("R5 read during write", rd_data, exp_box[5]);
    exp_box[5] = exp_box[5] | 32'h00F0_0000;
    do_read(clr_addr(5), v);
    check32("R5 read after write", v, exp_box[5]);

    // R4: partial clear keeps upper bits
    for (int i = 0; i < NB; i++) begin
      do_write(clr_addr(i), 32'h0000_FFFF);
      exp_box[i] = exp_box[i] & ~32'h0000_FFFF;
      check_irq("R4 level after partial clear");
    end
    check_all_reads("R4 contents after partial clear");

    // R4 R3 R8: full clear of odd mailboxes, then even
    for (int i = 1; i < NB; i += 2) begin
      do_write(clr_addr(i), '1);
      exp_box[i] = '0;
      check_irq("R3 R4 level after odd clear");
    end
    check_all_reads("R8 contents after odd clear");
    for (int i = 0; i < NB; i += 2) begin
      do_write(clr_addr(i), '1);
      exp_box[i] = '0;
      check_irq("R3 R4 level after even clear");
    end
    check_all_reads("R4 contents after full clear");

    // R9: reset in the middle of a run
    for (int i = 0; i < NB; i += 3) begin
      do_write(set_addr(i), 32'hA5A5_0000 | 32'(i));
      exp_box[i] = 32'hA5A5_0000 | 32'(i);
    end
    check_irq("R3 level before mid reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < NB; i++) exp_box[i] = '0;
    check_irq("R9 level after mid reset");
    check_all_reads("R9 contents after mid reset");

    finish_run();
  end
endmodule